// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Cell

This block is one cell of a grid that multiplies matrices with the weights held in place. Each cell keeps two copies of its weight. The shadow copy can be refilled while the cell keeps computing with the active copy, and a swap command then moves the shadow copy into the active copy. On every valid cycle the cell multiplies the incoming activation by the active weight in signed Q8.8 format. It adds the partial sum that arrives from the cell above, saturates the total to 16 bits and registers it for the cell below.

The activation and its valid flag are passed on to the cell on the right. The weight, the load flag and the partial sum are passed on to the cell below. The swap flag is also passed on, so a single pulse sweeps across the grid diagonally. Every forwarded output is registered, so each hop costs one cycle. The cell in the top row has its partial-sum input tied to zero. The enable input lets a column that is not in use stay out of the computation.

Top module: `wspe_cell`

## Requirements
- R1: A synchronous active-low reset (`rst_n` = 0 at a rising edge) sets every output to zero and clears both the shadow weight and the active weight. After reset, a swap followed by a valid cycle gives `psum_out` equal to `psum_in`.
- R2: At each rising edge, `act_out` takes `act_in`. `act_vld_out` takes `act_vld_in` AND `en`.
- R3: At each rising edge, `wgt_out`, `wgt_load_out` and `swap_out` take `wgt_in`, `wgt_load_in` and `swap_in`, whatever the value of `en`.
- R4: When `wgt_load_in` is 1 at an edge, `wgt_in` is written into the shadow weight only, and the product keeps using the previous active weight. When `wgt_load_in` is 0, the shadow weight holds its value even if `wgt_in` changes.
- R5: When `swap_in` is 1 at an edge, the active weight takes the shadow weight. From the next cycle on, products use the new active weight.
- R6: When swap and load arrive in the same cycle, the active weight takes the old shadow value and the shadow weight takes the new `wgt_in`.
- R7: When `act_vld_in` and `en` are both 1, `psum_out` at the next edge is `psum_in + ((act_in * w_active) >>> 8)`. All values are signed two's complement Q8.8, and the shift is arithmetic, so it rounds toward minus infinity.
- R8: A sum above 32767 gives 16'h7FFF, and a sum below -32768 gives 16'h8000.
- R9: When `act_vld_in` is 0 or `en` is 0, `psum_out` is registered as zero and `act_vld_out` as 0. `act_out` is still forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Column enable |
| act_in | input | 16 | Activation from the left neighbour (Q8.8) |
| act_vld_in | input | 1 | Activation valid |
| psum_in | input | 16 | Partial sum from the neighbour above (zero in the top row) |
| wgt_in | input | 16 | Weight from the neighbour above (Q8.8) |
| wgt_load_in | input | 1 | Write `wgt_in` into the shadow weight |
| swap_in | input | 1 | Copy the shadow weight into the active weight |
| act_out | output | 16 | Registered activation to the right neighbour |
| act_vld_out | output | 1 | Registered valid to the right neighbour |
| wgt_out | output | 16 | Registered weight to the neighbour below |
| wgt_load_out | output | 1 | Registered load flag to the neighbour below |
| swap_out | output | 1 | Registered swap flag to the neighbours |
| psum_out | output | 16 | Registered saturated partial sum to the neighbour below |

## Verification
The multiply-accumulate path is driven with a positive weight, with a negative fractional weight, and with a tiny negative product. Together these show whether the 8-bit scaling is correct and whether the shift is arithmetic, since a logical shift or a round-toward-zero would give a different result. Operands at full scale are driven in both directions to separate saturation from wrap-around. The weight path is driven with load and swap on their own, together in one cycle, and with `wgt_in` toggling while the load flag is low. The result is read from `psum_out` each time, which shows which register a weight actually reached. Idle cycles with valid low, and with enable low, confirm that the sum and the valid flag are forced to zero while the other flags are still forwarded.

// File: rtl/wspe_pkg.sv
// Package: shared constants and the control-flag bundle for the systolic cell.
// Assumes: two's complement Q-format data; all users take widths from here.
package wspe_pkg;
    localparam int WSPE_DATA_W = 16;
    localparam int WSPE_FRAC_W = 8;

    // Single-bit controls that travel alongside the data.
    typedef struct packed {
        logic act_vld;
        logic wgt_load;
        logic swap;
    } wspe_ctl_t;
endpackage

// File: rtl/wspe_weight_bank.sv
// Module: two-deep weight store. The shadow register is written on load;
// the active register takes the shadow value on swap.
// Assumes: load and swap may coincide; the active register then gets the
// shadow value from before this edge.
module wspe_weight_bank #(
    parameter int DATA_W = wspe_pkg::WSPE_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wgt_in,
    input  logic              load,
    input  logic              swap,
    output logic [DATA_W-1:0] active_w
);
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] active_q;

    // Purpose: update the shadow register and the active register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (load) shadow_q <= wgt_in;
            if (swap) active_q <= shadow_q;
        end
    end

    assign active_w = active_q;

    // R4: a load writes the shadow register; without a load it holds.
    a_r4_shadow_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> shadow_q == $past(wgt_in));
    a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(shadow_q));
    // R5: a swap moves the shadow value into the active register.
    a_r5_swap_copy: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> active_q == $past(shadow_q));
    // R6: with both in one cycle, active gets the old shadow value and shadow gets the new weight.
    a_r6_swap_and_load: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && load) |=> (active_q == $past(shadow_q)) && (shadow_q == $past(wgt_in)));
endmodule

// File: rtl/wspe_mac.sv
// Module: combinational Q-format multiply, arithmetic shift and saturating add.
// Assumes: all operands are signed two's complement with FRAC_W fraction bits.
module wspe_mac #(
    parameter int DATA_W = wspe_pkg::WSPE_DATA_W,
    parameter int FRAC_W = wspe_pkg::WSPE_FRAC_W
) (
    input  logic [DATA_W-1:0] act,
    input  logic [DATA_W-1:0] wgt,
    input  logic [DATA_W-1:0] psum,
    output logic [DATA_W-1:0] result
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam logic signed [SUM_W-1:0] SAT_MAX = SUM_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
    localparam logic signed [SUM_W-1:0] SAT_MIN = -SAT_MAX - SUM_W'(1);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] prod_scaled;
    logic signed [SUM_W-1:0]  sum_wide;

    // Purpose: form the full product, rescale it and add it at full width.
    always_comb begin
        prod        = PROD_W'($signed(act)) * PROD_W'($signed(wgt));
        prod_scaled = prod >>> FRAC_W;
        sum_wide    = SUM_W'($signed(psum)) + SUM_W'(prod_scaled);
    end

    // Purpose: clamp the wide sum to the output range.
    always_comb begin
        if (sum_wide > SAT_MAX)      result = {1'b0, {(DATA_W-1){1'b1}}};
        else if (sum_wide < SAT_MIN) result = {1'b1, {(DATA_W-1){1'b0}}};
        else                         result = sum_wide[DATA_W-1:0];
    end
endmodule

// File: rtl/wspe_cell.sv
// Module: one weight-stationary cell. It registers the activation and valid
// to the right, the weight, load, swap and partial sum downward, and the
// result of the saturating multiply-accumulate.
// Assumes: the cell in the top row has psum_in tied to zero by the grid.
module wspe_cell #(
    parameter int DATA_W = wspe_pkg::WSPE_DATA_W,
    parameter int FRAC_W = wspe_pkg::WSPE_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] act_in,
    input  logic              act_vld_in,
    input  logic [DATA_W-1:0] psum_in,
    input  logic [DATA_W-1:0] wgt_in,
    input  logic              wgt_load_in,
    input  logic              swap_in,
    output logic [DATA_W-1:0] act_out,
    output logic              act_vld_out,
    output logic [DATA_W-1:0] wgt_out,
    output logic              wgt_load_out,
    output logic              swap_out,
    output logic [DATA_W-1:0] psum_out
);
    import wspe_pkg::*;

    logic [DATA_W-1:0] active_w;
    logic [DATA_W-1:0] mac_result;
    logic              compute;
    wspe_ctl_t         ctl_q;

    assign compute = act_vld_in && en;

    wspe_weight_bank #(.DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wgt_in   (wgt_in),
        .load     (wgt_load_in),
        .swap     (swap_in),
        .active_w (active_w)
    );

    wspe_mac #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_mac (
        .act    (act_in),
        .wgt    (active_w),
        .psum   (psum_in),
        .result (mac_result)
    );

    // Purpose: register the data forwarded to the right and downward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_out  <= '0;
            wgt_out  <= '0;
            psum_out <= '0;
        end else begin
            act_out  <= act_in;
            wgt_out  <= wgt_in;
            psum_out <= compute ? mac_result : '0;
        end
    end

    // Purpose: register the control flags that travel with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= '{act_vld: compute, wgt_load: wgt_load_in, swap: swap_in};
    end

    assign act_vld_out  = ctl_q.act_vld;
    assign wgt_load_out = ctl_q.wgt_load;
    assign swap_out     = ctl_q.swap;

    // R1: after a reset edge every output is zero.
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) |-> (act_out == '0 && psum_out == '0 && wgt_out == '0
                           && !act_vld_out && !wgt_load_out && !swap_out));
    // R2: the activation is forwarded to the right one cycle later.
    a_r2_act_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> act_out == $past(act_in));
    // R3: weight, load and swap are forwarded downward one cycle later.
    a_r3_down_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (wgt_out == $past(wgt_in) && wgt_load_out == $past(wgt_load_in)
                          && swap_out == $past(swap_in)));
    // R9: an idle or disabled cycle yields a zero sum and a low valid.
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(act_vld_in) && $past(en))) |-> (psum_out == '0 && !act_vld_out));
endmodule

// File: tb/wspe_cell_tb.sv
`timescale 1ns/1ps
module wspe_cell_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] act_in = '0;
    logic        act_vld_in = 1'b0;
    logic [15:0] psum_in = '0;
    logic [15:0] wgt_in = '0;
    logic        wgt_load_in = 1'b0;
    logic        swap_in = 1'b0;
    logic [15:0] act_out, wgt_out, psum_out;
    logic        act_vld_out, wgt_load_out, swap_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wspe_cell u_dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .act_in(act_in), .act_vld_in(act_vld_in), .psum_in(psum_in),
        .wgt_in(wgt_in), .wgt_load_in(wgt_load_in), .swap_in(swap_in),
        .act_out(act_out), .act_vld_out(act_vld_out), .wgt_out(wgt_out),
        .wgt_load_out(wgt_load_out), .swap_out(swap_out), .psum_out(psum_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model from R7/R8: scaled product, floor shift, clamp.
    function automatic logic [15:0] ref_mac(input logic [15:0] p, input logic [15:0] a,
                                            input logic [15:0] w);
        longint prod, s;
        prod = longint'($signed(a)) * longint'($signed(w));
        prod = prod >>> 8;
        s = longint'($signed(p)) + prod;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s[15:0];
    endfunction

    task automatic idle_inputs();
        act_vld_in = 1'b0; wgt_load_in = 1'b0; swap_in = 1'b0; en = 1'b1;
    endtask

    task automatic load_weight(input logic [15:0] w);
        wgt_in = w; wgt_load_in = 1'b1;
        @(negedge clk);
        wgt_load_in = 1'b0;
    endtask

    task automatic do_swap();
        swap_in = 1'b1;
        @(negedge clk);
        swap_in = 1'b0;
    endtask

    task automatic compute(input string req, input logic [15:0] a, input logic [15:0] p,
                           input logic [15:0] exp);
        act_in = a; psum_in = p; act_vld_in = 1'b1; en = 1'b1;
        wgt_in = 16'h5A5A;
        @(negedge clk);
        check(req, psum_out, exp);
        check(req, {15'd0, act_vld_out}, 16'd1);
        act_vld_in = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en = 1'b1; act_in = 16'hFFFF; act_vld_in = 1'b1; psum_in = 16'h1111;
        wgt_in = 16'h7777; wgt_load_in = 1'b1; swap_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 act_out", act_out, 16'h0);
        check("R1 psum_out", psum_out, 16'h0);
        check("R1 wgt_out", wgt_out, 16'h0);
        check("R1 flags", {13'd0, act_vld_out, wgt_load_out, swap_out}, 16'h0);
        idle_inputs();
        rst_n = 1'b1;
        @(negedge clk);
        do_swap();
        compute("R1 active cleared", 16'h0100, 16'h0123, 16'h0123);
    endtask

    task automatic t_forward();
        act_in = 16'h1234; act_vld_in = 1'b1; en = 1'b1; psum_in = 16'h0;
        wgt_in = 16'h0ABC; wgt_load_in = 1'b1; swap_in = 1'b1;
        @(negedge clk);
        check("R2 act_out", act_out, 16'h1234);
        check("R2 act_vld_out", {15'd0, act_vld_out}, 16'd1);
        check("R3 wgt_out", wgt_out, 16'h0ABC);
        check("R3 load/swap out", {14'd0, wgt_load_out, swap_out}, 16'd3);
        en = 1'b0; wgt_load_in = 1'b0; swap_in = 1'b0; act_in = 16'h4321; wgt_in = 16'h0DEF;
        @(negedge clk);
        check("R3 disabled wgt_out", wgt_out, 16'h0DEF);
        check("R3 load/swap out low", {14'd0, wgt_load_out, swap_out}, 16'd0);
        idle_inputs();
        @(negedge clk);
    endtask

    task automatic t_shadow_swap();
        load_weight(16'h0100);
        do_swap();
        load_weight(16'h0200);
        compute("R4 active unchanged by load", 16'h0100, 16'h0005, 16'h0105);
        wgt_in = 16'h7F00;
        repeat (2) @(negedge clk);
        do_swap();
        compute("R5 swap takes shadow", 16'h0100, 16'h0005, 16'h0205);
        do_swap();
        compute("R4 shadow held without load", 16'h0100, 16'h0000, 16'h0200);
    endtask

    task automatic t_swap_and_load();
        load_weight(16'h0300);
        wgt_in = 16'h0080; wgt_load_in = 1'b1; swap_in = 1'b1;
        @(negedge clk);
        wgt_load_in = 1'b0; swap_in = 1'b0;
        compute("R6 active gets old shadow", 16'h0100, 16'h0000, 16'h0300);
        do_swap();
        compute("R6 shadow gets new weight", 16'h0100, 16'h0000, 16'h0080);
    endtask

    task automatic t_arith();
        load_weight(16'hFF80);
        do_swap();
        compute("R7 negative fractional", 16'h0300, 16'h0100, ref_mac(16'h0100, 16'h0300, 16'hFF80));
        check("R7 ref value", ref_mac(16'h0100, 16'h0300, 16'hFF80), 16'hFF80);
        compute("R7 floor shift", 16'h0001, 16'h0000, 16'hFFFF);
        compute("R7 mixed", 16'hFD40, 16'h0123, ref_mac(16'h0123, 16'hFD40, 16'hFF80));
    endtask

    task automatic t_saturate();
        load_weight(16'h7FFF);
        do_swap();
        compute("R8 positive clamp", 16'h7FFF, 16'h7FFF, 16'h7FFF);
        compute("R8 negative clamp", 16'h8000, 16'h8000, 16'h8000);
    endtask

    task automatic t_idle();
        act_in = 16'h0400; psum_in = 16'h0400; act_vld_in = 1'b0; en = 1'b1;
        @(negedge clk);
        check("R9 invalid psum", psum_out, 16'h0);
        check("R9 invalid vld", {15'd0, act_vld_out}, 16'd0);
        act_vld_in = 1'b1; en = 1'b0; act_in = 16'h0404;
        @(negedge clk);
        check("R9 disabled psum", psum_out, 16'h0);
        check("R9 disabled vld", {15'd0, act_vld_out}, 16'd0);
        check("R9 act still forwarded", act_out, 16'h0404);
        idle_inputs();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_forward();
        t_shadow_swap();
        t_swap_and_load();
        t_arith();
        t_saturate();
        t_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule